// File: doc/BRIEF.md
# Butterfly bit network with programmable pair functions

The block rearranges and combines the bits of a word in a chain of butterfly stages. Stage i has stride 2^i. Each stage pairs every bit with the bit whose index differs by that stride. When a stage is enabled, each bit of the pair is replaced by a 2-input lookup of the two bits. Two 4-bit tables, taken from an 8-bit immediate, decide what each stage does. One table value gives plain generalised bit reversal. Another gives OR-combine. Other values make new functions.

The starting word (the seed) is either the data input or a built-in alternating constant. The seed can be inverted before the network. With the constant seed, a single setting produces many regular masks, such as one bit per nibble or one bit per byte. A half-width mode limits the network to the lower half of the word. A second variant takes a separate table byte for every stage from the amount operand, and then applies every stage. The datapath is purely combinational.

Top module: `grl_unit`

## Requirements
- R1: When `src_zero` is 1, the seed is the constant with every even-numbered bit set (0x5555_5555_5555_5555) and `data_in` has no effect. When `src_zero` is 0, the seed is `data_in`.
- R2: When `invert` is 1, the seed is complemented before any stage. A constant seed with inversion is 0xAAAA_AAAA_AAAA_AAAA.
- R3: In amount mode (`per_stage`=0), stage i (stride 2^i) runs only when bit i of `amount_in` is 1. Stages apply in order of increasing stride. Bits of `amount_in` above bit 5 have no effect, and an amount of zero returns the seed unchanged.
- R4: In a running stage, let L be the bit of a pair whose index has the stride bit clear, and H the bit whose index has it set. Both output bits are looked up at index {L,H} (L is the index MSB). The L position reads table `imm[3:0]`, and the H position reads table `imm[7:4]`.
- R5: Immediate 0xCA makes every running stage swap the two bits of each pair, which gives plain generalised reverse.
- R6: Immediate 0xEE makes every running stage OR each bit with its partner, which gives OR-combine.
- R7: With a constant seed and `imm`=0x6C, amounts 0b10, 0b110 and 0b1110 give 0x1111..., 0x0101... and 0x00010001.... With inversion and `imm`=0xC6, the same amounts give 0x8888..., 0x8080... and 0x80008000....
- R8: In half mode (`half_mode`=1), only the lower 32 bits take part, only stages 0 to 4 exist, bit 5 of the amount has no effect, and `result[63:32]` is zero.
- R9: In the per-stage variant (`per_stage`=1), byte i of `amount_in` (bits 8i+7..8i) is the table pair for stage i, and every stage is applied. Table 0xAC leaves a stage as identity. `imm` has no effect in this variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 64 | Word used as seed when no constant is selected |
| src_zero | input | 1 | Selects the alternating constant seed |
| invert | input | 1 | Complements the seed |
| half_mode | input | 1 | Lower-half operation, upper result bits zero |
| per_stage | input | 1 | Per-stage table variant select |
| amount_in | input | 64 | Stage-enable amount, or the per-stage table bytes |
| imm | input | 8 | Pair of 4-bit lookup tables for amount mode |
| result | output | 64 | Network output |

## Verification
The hardest case to reach is a proof that the two table halves are never swapped and the lookup index is never reversed. Tables like the swap and OR-combine settings are symmetric enough to hide such a fault. The stimulus therefore sweeps every immediate against every amount, using pseudo-random data and seed options. The per-stage variant is driven with identity bytes in all stages but one, so each stride's table byte position is seen on its own.

// File: rtl/grl_pkg.sv
package grl_pkg;
   // width of one table pair (two 4-bit LUT2 tables)
   localparam int GRL_TBL_W = 8;
   // table pair that exchanges the two bits of every pair
   localparam logic [GRL_TBL_W-1:0] GRL_TBL_SWAP = 8'hCA;
   // table pair that ORs every bit with its partner
   localparam logic [GRL_TBL_W-1:0] GRL_TBL_ORC  = 8'hEE;
   // table pair that leaves every bit unchanged
   localparam logic [GRL_TBL_W-1:0] GRL_TBL_IDENT = 8'hAC;
endpackage

// File: rtl/grl_seed.sv
module grl_seed #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic              src_zero,
   input  logic              invert,
   input  logic              half_mode,
   output logic [DATA_W-1:0] seed
);
   localparam int HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] ALT_CONST = {HALF_W{2'b01}};
   localparam logic [DATA_W-1:0] LOW_MASK  = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

   logic [DATA_W-1:0] picked;
   logic [DATA_W-1:0] flipped;

   assign picked  = src_zero ? ALT_CONST : data_in;
   assign flipped = invert ? ~picked : picked;
   assign seed    = half_mode ? (flipped & LOW_MASK) : flipped;
endmodule

// File: rtl/grl_ctrl.sv
module grl_ctrl
   import grl_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int STAGES = 6
) (
   input  logic [DATA_W-1:0]           amount_in,
   input  logic [GRL_TBL_W-1:0]        imm,
   input  logic                        half_mode,
   input  logic                        per_stage,
   output logic [STAGES-1:0]           stg_en,
   output logic [STAGES*GRL_TBL_W-1:0] stg_tbl
);
   localparam int USED_W = STAGES * GRL_TBL_W;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic live;
      if (i == STAGES - 1) begin : g_top
         assign live = ~half_mode;
      end else begin : g_low
         assign live = 1'b1;
      end
      assign stg_en[i] = live & (per_stage | amount_in[i]);
      assign stg_tbl[i*GRL_TBL_W +: GRL_TBL_W] =
         per_stage ? amount_in[i*GRL_TBL_W +: GRL_TBL_W] : imm;
   end

   if (DATA_W > USED_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^amount_in[DATA_W-1:USED_W];
   end
endmodule

// File: rtl/grl_stage.sv
module grl_stage
   import grl_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int STRIDE = 1
) (
   input  logic                 en,
   input  logic [GRL_TBL_W-1:0] tbl,
   input  logic [DATA_W-1:0]    din,
   output logic [DATA_W-1:0]    dout
);
   logic [DATA_W-1:0] mixed;

   for (genvar j = 0; j < DATA_W; j++) begin : g_bit
      localparam int PART  = j ^ STRIDE;
      localparam bit UPPER = (j & STRIDE) != 0;
      logic [1:0] idx;
      logic [3:0] lut;
      if (UPPER) begin : g_hi
         assign idx = {din[PART], din[j]};
         assign lut = tbl[7:4];
      end else begin : g_lo
         assign idx = {din[j], din[PART]};
         assign lut = tbl[3:0];
      end
      assign mixed[j] = lut[idx];
   end

   assign dout = en ? mixed : din;
endmodule

// File: rtl/grl_unit.sv
module grl_unit
   import grl_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]    data_in,
   input  logic                 src_zero,
   input  logic                 invert,
   input  logic                 half_mode,
   input  logic                 per_stage,
   input  logic [DATA_W-1:0]    amount_in,
   input  logic [GRL_TBL_W-1:0] imm,
   output logic [DATA_W-1:0]    result
);
   localparam int STAGES = $clog2(DATA_W);
   localparam int HALF_W = DATA_W / 2;

   if ((1 << STAGES) != DATA_W) begin : g_bad_pow2
      $error("grl_unit: DATA_W must be a power of two");
   end
   if (STAGES * GRL_TBL_W > DATA_W) begin : g_bad_tbl
      $error("grl_unit: DATA_W too narrow to hold one table byte per stage");
   end

   function automatic logic [DATA_W-1:0] pair_swap(input logic [DATA_W-1:0] v,
                                                   input int s);
      logic [DATA_W-1:0] r;
      for (int k = 0; k < DATA_W; k++) r[k] = v[k ^ s];
      return r;
   endfunction

   logic [DATA_W-1:0]           seed;
   logic [STAGES-1:0]           stg_en;
   logic [STAGES*GRL_TBL_W-1:0] stg_tbl;
   logic [DATA_W-1:0]           chain [STAGES+1];

   grl_seed #(.DATA_W(DATA_W)) u_seed (
      .data_in  (data_in),
      .src_zero (src_zero),
      .invert   (invert),
      .half_mode(half_mode),
      .seed     (seed)
   );

   grl_ctrl #(.DATA_W(DATA_W), .STAGES(STAGES)) u_ctrl (
      .amount_in(amount_in),
      .imm      (imm),
      .half_mode(half_mode),
      .per_stage(per_stage),
      .stg_en   (stg_en),
      .stg_tbl  (stg_tbl)
   );

   assign chain[0] = seed;

   for (genvar i = 0; i < STAGES; i++) begin : g_net
      localparam int STRIDE = 1 << i;
      grl_stage #(.DATA_W(DATA_W), .STRIDE(STRIDE)) u_stage (
         .en  (stg_en[i]),
         .tbl (stg_tbl[i*GRL_TBL_W +: GRL_TBL_W]),
         .din (chain[i]),
         .dout(chain[i+1])
      );

      always_comb begin
         // R3
         if (!per_stage && !amount_in[i]) begin
            stage_skip_chk: assert (chain[i+1] == chain[i])
               else $error("stage %0d changed data while disabled", i);
         end
         // R5
         if (stg_en[i] && stg_tbl[i*GRL_TBL_W +: GRL_TBL_W] == GRL_TBL_SWAP) begin
            stage_swap_chk: assert (chain[i+1] == pair_swap(chain[i], STRIDE))
               else $error("stage %0d swap table did not exchange pairs", i);
         end
         // R6
         if (stg_en[i] && stg_tbl[i*GRL_TBL_W +: GRL_TBL_W] == GRL_TBL_ORC) begin
            stage_orc_chk: assert (chain[i+1] == (chain[i] | pair_swap(chain[i], STRIDE)))
               else $error("stage %0d OR table did not combine pairs", i);
         end
         // R9
         if (per_stage && stg_en[i] &&
             stg_tbl[i*GRL_TBL_W +: GRL_TBL_W] == GRL_TBL_IDENT) begin
            stage_ident_chk: assert (chain[i+1] == chain[i])
               else $error("stage %0d identity table altered data", i);
         end
      end
   end

   assign result = half_mode ? {{HALF_W{1'b0}}, chain[STAGES][HALF_W-1:0]}
                             : chain[STAGES];

   always_comb begin
      // R1
      if (src_zero && !invert && !half_mode) begin
         seed_const_chk: assert (seed == {HALF_W{2'b01}})
            else $error("constant seed wrong");
      end
      // R8
      if (half_mode) begin
         half_upper_chk: assert (result[DATA_W-1:HALF_W] == '0)
            else $error("upper half nonzero in half mode");
      end
   end
endmodule

// File: tb/grl_unit_test.sv
module grl_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] data_in = '0;
   logic        src_zero = 1'b0;
   logic        invert = 1'b0;
   logic        half_mode = 1'b0;
   logic        per_stage = 1'b0;
   logic [63:0] amount_in = '0;
   logic [7:0]  imm = '0;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   logic [63:0] rs = 64'h9E3779B97F4A7C15;

   always #(CLK_PERIOD/2) clk = ~clk;

   grl_unit #(.DATA_W(64)) uut (
      .data_in(data_in), .src_zero(src_zero), .invert(invert),
      .half_mode(half_mode), .per_stage(per_stage), .amount_in(amount_in),
      .imm(imm), .result(result)
   );

   function automatic logic [63:0] next_rand(input logic [63:0] v);
      logic [63:0] x;
      x = v;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   function automatic logic [63:0] ref_model(input logic [63:0] d, input logic sz,
         input logic inv, input logic [63:0] amt, input logic [7:0] im,
         input logic half, input logic per);
      logic [63:0] x, y;
      logic [7:0]  t;
      logic [3:0]  tb;
      logic        lo, hi;
      int          ns, st;
      x = sz ? 64'h5555555555555555 : d;
      if (inv) x = ~x;
      if (half) x[63:32] = '0;
      ns = half ? 5 : 6;
      for (int s = 0; s < ns; s++) begin
         st = 1 << s;
         if (per || amt[s]) begin
            t = per ? amt[8*s +: 8] : im;
            for (int j = 0; j < 64; j++) begin
               if ((j & st) == 0) begin lo = x[j];      hi = x[j+st]; tb = t[3:0]; end
               else               begin lo = x[j-st];   hi = x[j];    tb = t[7:4]; end
               y[j] = tb[{lo, hi}];
            end
            x = y;
         end
      end
      if (half) x[63:32] = '0;
      return x;
   endfunction

   function automatic logic [63:0] classic_net(input logic [63:0] d,
         input logic [5:0] amt, input logic orc);
      logic [63:0] x, m, sw;
      int st;
      x = d;
      for (int s = 0; s < 6; s++) begin
         st = 1 << s;
         if (amt[s]) begin
            for (int k = 0; k < 64; k++) m[k] = ((k & st) == 0);
            sw = ((x & m) << st) | ((x & ~m) >> st);
            x = orc ? (x | sw) : sw;
         end
      end
      return x;
   endfunction

   task automatic drive(input logic [63:0] d, input logic sz, input logic inv,
                        input logic [63:0] amt, input logic [7:0] im,
                        input logic half, input logic per);
      @(posedge clk);
      data_in = d; src_zero = sz; invert = inv; amount_in = amt;
      imm = im; half_mode = half; per_stage = per;
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] d, a, pa;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset-like idle state: all inputs zero
      drive('0, 0, 0, '0, '0, 0, 0);
      check("R3 idle", result, 64'h0);

      // R1 constant seed, data ignored
      drive(64'hDEADBEEF01234567, 1, 0, '0, 8'hCA, 0, 0);
      check("R1 const seed", result, 64'h5555555555555555);
      drive(64'h0123456789ABCDEF, 0, 0, '0, 8'h00, 0, 0);
      check("R1 data seed", result, 64'h0123456789ABCDEF);

      // R2 inversion
      drive(64'hFFFF0000FFFF0000, 1, 1, '0, 8'h00, 0, 0);
      check("R2 inverted const", result, 64'hAAAAAAAAAAAAAAAA);
      drive(64'h0123456789ABCDEF, 0, 1, '0, 8'h00, 0, 0);
      check("R2 inverted data", result, ~64'h0123456789ABCDEF);

      // R7 pattern constants
      drive('0, 1, 0, 64'h2, 8'h6C, 0, 0);  check("R7 1111", result, 64'h1111111111111111);
      drive('0, 1, 0, 64'h6, 8'h6C, 0, 0);  check("R7 0101", result, 64'h0101010101010101);
      drive('0, 1, 0, 64'hE, 8'h6C, 0, 0);  check("R7 0001", result, 64'h0001000100010001);
      drive('0, 1, 1, 64'h2, 8'hC6, 0, 0);  check("R7 8888", result, 64'h8888888888888888);
      drive('0, 1, 1, 64'h6, 8'hC6, 0, 0);  check("R7 8080", result, 64'h8080808080808080);
      drive('0, 1, 1, 64'hE, 8'hC6, 0, 0);  check("R7 8000", result, 64'h8000800080008000);

      // R3 amount bits above 5 ignored
      for (int n = 0; n < 64; n++) begin
         rs = next_rand(rs); d = rs; rs = next_rand(rs); a = rs;
         drive(d, 0, 0, a, 8'h6C, 0, 0);
         check("R3 high amount bits", result, ref_model(d, 0, 0, {58'h0, a[5:0]}, 8'h6C, 0, 0));
      end

      // R5 and R6 against classic mask-and-shift networks, every amount
      for (int n = 0; n < 64; n++) begin
         rs = next_rand(rs); d = rs;
         drive(d, 0, 0, 64'(n), 8'hCA, 0, 0);
         check("R5 grev", result, classic_net(d, 6'(n), 1'b0));
         drive(d, 0, 0, 64'(n), 8'hEE, 0, 0);
         check("R6 orc", result, classic_net(d, 6'(n), 1'b1));
      end

      // R4 exhaustive amount x immediate
      for (int am = 0; am < 64; am++) begin
         for (int im = 0; im < 256; im++) begin
            rs = next_rand(rs); d = rs;
            drive(d, rs[7], rs[9], {rs[63:56], 50'h0, 6'(am)}, 8'(im), 0, 0);
            check("R4 lut network", result,
                  ref_model(d, rs[7], rs[9], 64'(am), 8'(im), 0, 0));
         end
      end

      // R8 half mode sweep, bit 5 of amount toggled freely
      for (int am = 0; am < 64; am++) begin
         for (int im = 0; im < 256; im += 3) begin
            rs = next_rand(rs); d = rs;
            drive(d, rs[3], rs[5], 64'(am), 8'(im), 1, 0);
            check("R8 half mode", result,
                  ref_model(d, rs[3], rs[5], 64'(am & 31), 8'(im), 1, 0));
         end
      end
      drive(64'hFFFFFFFFFFFFFFFF, 0, 0, 64'h20, 8'hCA, 1, 0);
      check("R8 stride32 off", result, 64'h00000000FFFFFFFF);

      // R9 per-stage: all identity
      pa = {16'h0, {6{8'hAC}}};
      for (int n = 0; n < 16; n++) begin
         rs = next_rand(rs); d = rs;
         drive(d, 0, 0, pa, rs[15:8], 0, 1);
         check("R9 identity", result, d);
      end
      // R9 one swap byte per stage position
      for (int k = 0; k < 6; k++) begin
         rs = next_rand(rs); d = rs;
         pa = {16'h0, {6{8'hAC}}};
         pa[8*k +: 8] = 8'hCA;
         drive(d, 0, 0, pa, 8'h00, 0, 1);
         check("R9 single stage swap", result, classic_net(d, 6'(1 << k), 1'b0));
      end
      // R9 random table bytes, both widths
      for (int n = 0; n < 2000; n++) begin
         rs = next_rand(rs); d = rs; rs = next_rand(rs); pa = rs;
         drive(d, pa[63], pa[62], pa, d[7:0], n[0], 1);
         check("R9 per stage random", result,
               ref_model(d, pa[63], pa[62], pa, d[7:0], n[0], 1));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule